// File: doc/BRIEF.md
# Interrupt Acknowledge Instruction Injector

This block sits beside an 8080-style processor and acts as its interrupt source. Software raises the request line by writing to an I/O port. When the processor acknowledges, the block places a programmed response on the data bus. The response is one, two or three bytes long. A one-byte response is normally a restart opcode. A three-byte response is a CALL opcode followed by the low and then the high byte of the target address.

The block looks at the latched status byte at the start of every machine cycle. It keeps a response byte index from 0 to 2. An acknowledge status restarts the response at byte 0. An address-fetch status serves the next byte, but only while a response is in progress. Any other status ends the response.

Some clone processors do not mask interrupts internally during a CALL response. Left alone, such a processor repeats the acknowledge sequence for as long as the request stays high. An optional workaround drops the request while the last byte of a multi-byte response is being supplied. The block also sets a sticky clone-detected flag when it sees the clone's address-fetch status, and software can read that flag and clear it.

Top module: `inta_injector`

## Requirements
- R1: After reset, `irq` is 0, `inject_oe` is 0, `inject_data` is 0, the workaround is enabled, the response length is 1 and the opcode byte is 0xFF. Reading the status port (base+2) returns 0x04. The status byte layout is: bit0 clone-detected, bit1 request level, bit2 workaround enable.
- R2: A write to the request port (base+0) sets `irq` to bit0 of the written data from the next cycle on.
- R3: A cycle start with status 0x23 (acknowledge) always restarts the response. From the next cycle on, `inject_oe` is 1 and `inject_data` holds response byte 0, which is set through port base+3.
- R4: With length 1, a following fetch status is not served (`inject_oe` is 0). If the workaround has nothing to drop, the request stays high through stack cycles, and the next acknowledge is served again.
- R5: With length 3, the two fetch cycles after an acknowledge supply byte 1 (port base+4) and then byte 2 (port base+5). Status 0x02 and status 0x03 are both accepted as fetch cycles.
- R6: With length 2, exactly one fetch cycle is served (byte 1), and the next fetch status is not served.
- R7: With the workaround enabled and length greater than 1, `irq` is 0 from the cycle after the cycle start at which the last byte is served.
- R8: With the workaround enabled, a fetch with status 0x03 during a response drops `irq` and sets the sticky clone-detected bit.
- R9: With the workaround disabled, `irq` stays high through any response, repeated acknowledges keep being answered, and the clone-detected bit stays 0.
- R10: A cycle-start status other than 0x23, 0x02 or 0x03 ends the response and drives `inject_oe` to 0. A fetch status with no response in progress is not served.
- R11: Writing the status port with bit0=1 clears the clone-detected bit. Writing it with bit0=0 leaves the bit unchanged.
- R12: A write to the control port (base+1) sets the workaround enable from bit0 and the response length from bits 2:1 (0 counts as 1). The workaround enable reads back at status bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle pulse at the start of each machine cycle |
| status | input | 8 | Latched processor status byte |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (status port), 0 otherwise |
| inject_oe | output | 1 | Response byte is being driven onto the data bus |
| inject_data | output | 8 | Response byte |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: three response bytes, a port base of 0x40, and status codes 0x23, 0x02 and 0x03. Three response bytes make the one-, two- and three-byte lengths all reachable through the 2-bit length field. With the workaround switched off, a vector table plays a clone acknowledge loop and a compliant acknowledge sequence. Directed runs then cover the early request drop, clone detection with its sticky clear, stray cycles that end a response, and the single-byte restart with the request held high.

// File: rtl/inta_pkg.sv
package inta_pkg;

    localparam int BUS_W = 8;

    // Port offsets from the base address
    localparam int OFF_REQ   = 0;
    localparam int OFF_CTRL  = 1;
    localparam int OFF_STAT  = 2;
    localparam int OFF_BYTE0 = 3;

    typedef enum logic [1:0] {
        CLS_OTHER,
        CLS_ACK,
        CLS_FETCH_STD,
        CLS_FETCH_CLONE
    } cyc_class_e;

    typedef struct packed {
        logic             drive;
        logic [BUS_W-1:0] data;
    } inject_t;

    typedef struct packed {
        logic drop;
        logic clone;
    } seq_evt_t;

    function automatic cyc_class_e classify(
        input logic [BUS_W-1:0] st,
        input logic [BUS_W-1:0] ack_code,
        input logic [BUS_W-1:0] std_code,
        input logic [BUS_W-1:0] clone_code
    );
        if (st == ack_code)        return CLS_ACK;
        else if (st == std_code)   return CLS_FETCH_STD;
        else if (st == clone_code) return CLS_FETCH_CLONE;
        else                       return CLS_OTHER;
    endfunction

endpackage

// File: rtl/inta_regs.sv
module inta_regs import inta_pkg::*; #(
    parameter int               AW           = 8,
    parameter int               BASE_PORT    = 'h40,
    parameter int               MAX_BYTES    = 3,
    parameter int               LEN_W        = 2,
    parameter logic [BUS_W-1:0] RESET_OPCODE = 8'hFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       io_wr,
    input  logic [AW-1:0]              io_addr,
    input  logic [BUS_W-1:0]           io_wdata,
    input  seq_evt_t                   evt,
    output logic                       irq,
    output logic                       wa_en,
    output logic                       clone_flag,
    output logic [LEN_W-1:0]           resp_len,
    output logic [MAX_BYTES*BUS_W-1:0] resp_bytes
);

    localparam logic [AW-1:0] PORT_REQ  = AW'(BASE_PORT + OFF_REQ);
    localparam logic [AW-1:0] PORT_CTRL = AW'(BASE_PORT + OFF_CTRL);
    localparam logic [AW-1:0] PORT_STAT = AW'(BASE_PORT + OFF_STAT);

    logic wr_req, wr_ctrl, wr_stat;
    assign wr_req  = io_wr && (io_addr == PORT_REQ);
    assign wr_ctrl = io_wr && (io_addr == PORT_CTRL);
    assign wr_stat = io_wr && (io_addr == PORT_STAT);

    // A drop from the sequencer takes precedence over a software write
    always_ff @(posedge clk) begin
        if (rst)            irq <= 1'b0;
        else if (evt.drop)  irq <= 1'b0;
        else if (wr_req)    irq <= io_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_en    <= 1'b1;
            resp_len <= LEN_W'(1);
        end else if (wr_ctrl) begin
            wa_en    <= io_wdata[0];
            resp_len <= io_wdata[LEN_W:1];
        end
    end

    // A new detection in the same cycle beats the write-one clear
    always_ff @(posedge clk) begin
        if (rst)                          clone_flag <= 1'b0;
        else if (evt.clone)               clone_flag <= 1'b1;
        else if (wr_stat && io_wdata[0])  clone_flag <= 1'b0;
    end

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
        localparam logic [AW-1:0]    PORT_K  = AW'(BASE_PORT + OFF_BYTE0 + k);
        localparam logic [BUS_W-1:0] INIT_K  = (k == 0) ? RESET_OPCODE : '0;
        logic [BUS_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                              q <= INIT_K;
            else if (io_wr && io_addr == PORT_K)  q <= io_wdata;
        end
        assign resp_bytes[k*BUS_W +: BUS_W] = q;
    end

endmodule

// File: rtl/inta_seq.sv
module inta_seq import inta_pkg::*; #(
    parameter int               MAX_BYTES        = 3,
    parameter int               IDX_W            = 2,
    parameter int               LEN_W            = 2,
    parameter logic [BUS_W-1:0] ACK_CODE         = 8'h23,
    parameter logic [BUS_W-1:0] FETCH_STD_CODE   = 8'h02,
    parameter logic [BUS_W-1:0] FETCH_CLONE_CODE = 8'h03
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cyc_start,
    input  logic [BUS_W-1:0]           status,
    input  logic                       wa_en,
    input  logic [LEN_W-1:0]           resp_len,
    input  logic [MAX_BYTES*BUS_W-1:0] resp_bytes,
    output inject_t                    inj,
    output logic [IDX_W-1:0]           idx,
    output seq_evt_t                   evt
);

    logic [BUS_W-1:0] byte_arr [MAX_BYTES];
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_sel
        assign byte_arr[k] = resp_bytes[k*BUS_W +: BUS_W];
    end

    cyc_class_e       cls;
    logic             serve;
    logic             last;
    logic [IDX_W-1:0] sel;
    int               eff_len;

    always_comb begin
        cls = classify(status, ACK_CODE, FETCH_STD_CODE, FETCH_CLONE_CODE);

        if (resp_len == '0)                   eff_len = 1;
        else if (int'(resp_len) > MAX_BYTES)  eff_len = MAX_BYTES;
        else                                  eff_len = int'(resp_len);

        serve = 1'b0;
        sel   = '0;
        if (cyc_start) begin
            unique case (cls)
                CLS_ACK: begin
                    serve = 1'b1;
                    sel   = '0;
                end
                CLS_FETCH_STD, CLS_FETCH_CLONE: begin
                    serve = (idx != '0);
                    sel   = idx;
                end
                default: serve = 1'b0;
            endcase
        end
        last = serve && (int'(sel) == eff_len - 1);

        evt.clone = cyc_start && wa_en && (cls == CLS_FETCH_CLONE) && (idx != '0);
        evt.drop  = evt.clone || (wa_en && last && eff_len > 1);
    end

    always_ff @(posedge clk) begin
        if (rst)            idx <= '0;
        else if (cyc_start) idx <= (serve && !last) ? sel + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inj <= '0;
        end else if (cyc_start) begin
            inj.drive <= serve;
            inj.data  <= serve ? byte_arr[sel] : '0;
        end
    end

endmodule

// File: rtl/inta_injector.sv
module inta_injector import inta_pkg::*; #(
    parameter int               AW               = 8,
    parameter int               BASE_PORT        = 'h40,
    parameter int               MAX_BYTES        = 3,
    parameter logic [BUS_W-1:0] ACK_CODE         = 8'h23,
    parameter logic [BUS_W-1:0] FETCH_STD_CODE   = 8'h02,
    parameter logic [BUS_W-1:0] FETCH_CLONE_CODE = 8'h03,
    parameter logic [BUS_W-1:0] RESET_OPCODE     = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic [BUS_W-1:0] status,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [AW-1:0]    io_addr,
    input  logic [BUS_W-1:0] io_wdata,
    output logic [BUS_W-1:0] io_rdata,
    output logic             inject_oe,
    output logic [BUS_W-1:0] inject_data,
    output logic             irq
);

    localparam int            IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int            LEN_W     = $clog2(MAX_BYTES + 1);
    localparam logic [AW-1:0] PORT_STAT = AW'(BASE_PORT + OFF_STAT);

    seq_evt_t                   evt;
    inject_t                    inj;
    logic                       wa_en;
    logic                       clone_flag;
    logic [LEN_W-1:0]           resp_len;
    logic [MAX_BYTES*BUS_W-1:0] resp_bytes;
    logic [IDX_W-1:0]           seq_idx;

    inta_regs #(
        .AW(AW), .BASE_PORT(BASE_PORT), .MAX_BYTES(MAX_BYTES),
        .LEN_W(LEN_W), .RESET_OPCODE(RESET_OPCODE)
    ) u_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .evt(evt), .irq(irq), .wa_en(wa_en),
        .clone_flag(clone_flag), .resp_len(resp_len), .resp_bytes(resp_bytes)
    );

    inta_seq #(
        .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W),
        .ACK_CODE(ACK_CODE), .FETCH_STD_CODE(FETCH_STD_CODE),
        .FETCH_CLONE_CODE(FETCH_CLONE_CODE)
    ) u_seq (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .status(status),
        .wa_en(wa_en), .resp_len(resp_len), .resp_bytes(resp_bytes),
        .inj(inj), .idx(seq_idx), .evt(evt)
    );

    assign inject_oe   = inj.drive;
    assign inject_data = inj.data;
    assign io_rdata    = (io_rd && io_addr == PORT_STAT)
                       ? BUS_W'({wa_en, irq, clone_flag}) : '0;

endmodule

// File: rtl/inta_injector_chk.sv
module inta_injector_chk import inta_pkg::*; #(
    parameter int               IDX_W            = 2,
    parameter logic [BUS_W-1:0] ACK_CODE         = 8'h23,
    parameter logic [BUS_W-1:0] FETCH_STD_CODE   = 8'h02,
    parameter logic [BUS_W-1:0] FETCH_CLONE_CODE = 8'h03
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_start,
    input logic [BUS_W-1:0] status,
    input logic             io_wr,
    input logic             inject_oe,
    input logic [BUS_W-1:0] inject_data,
    input logic             irq,
    input logic             wa_en,
    input logic             clone_flag,
    input logic [IDX_W-1:0] idx,
    input logic [BUS_W-1:0] op0
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !inject_oe));

    p_ack_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && status == ACK_CODE) |=> (inject_oe && inject_data == $past(op0)));

    p_stray_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && status != ACK_CODE && status != FETCH_STD_CODE
         && status != FETCH_CLONE_CODE) |=> !inject_oe);

    p_clone_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && status == FETCH_CLONE_CODE && idx != '0 && wa_en)
        |=> (!irq && clone_flag));

    p_hold_no_wa_r9: assert property (@(posedge clk) disable iff (rst)
        (!wa_en && irq && !io_wr) |=> irq);

    p_flag_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(clone_flag) |-> $past(cyc_start && status == FETCH_CLONE_CODE));

endmodule

bind inta_injector inta_injector_chk #(
    .IDX_W(IDX_W), .ACK_CODE(ACK_CODE),
    .FETCH_STD_CODE(FETCH_STD_CODE), .FETCH_CLONE_CODE(FETCH_CLONE_CODE)
) u_chk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .status(status),
    .io_wr(io_wr), .inject_oe(inject_oe), .inject_data(inject_data),
    .irq(irq), .wa_en(wa_en), .clone_flag(clone_flag), .idx(seq_idx),
    .op0(resp_bytes[BUS_W-1:0])
);

// File: tb/tb_inta_injector.sv
`timescale 1ns/1ps
module tb_inta_injector;

    localparam logic [7:0] P_REQ  = 8'h40;
    localparam logic [7:0] P_CTRL = 8'h41;
    localparam logic [7:0] P_STAT = 8'h42;
    localparam logic [7:0] P_B0   = 8'h43;
    localparam logic [7:0] P_B1   = 8'h44;
    localparam logic [7:0] P_B2   = 8'h45;

    logic       clk = 0;
    logic       rst = 1;
    logic       cyc_start = 0;
    logic [7:0] status = 0;
    logic       io_wr = 0;
    logic       io_rd = 0;
    logic [7:0] io_addr = 0;
    logic [7:0] io_wdata = 0;
    logic [7:0] io_rdata;
    logic       inject_oe;
    logic [7:0] inject_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    inta_injector dut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .status(status),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .inject_oe(inject_oe), .inject_data(inject_data),
        .irq(irq)
    );

    // {status, exp_oe, exp_data, exp_irq}; workaround off, length 3, CALL 0x1234
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {8'h23, 1'b1, 8'hCD, 1'b1},
        {8'h03, 1'b1, 8'h34, 1'b1},
        {8'h03, 1'b1, 8'h12, 1'b1},
        {8'h05, 1'b0, 8'h00, 1'b1},
        {8'h05, 1'b0, 8'h00, 1'b1},
        {8'h23, 1'b1, 8'hCD, 1'b1},
        {8'h02, 1'b1, 8'h34, 1'b1},
        {8'h02, 1'b1, 8'h12, 1'b1},
        {8'h04, 1'b0, 8'h00, 1'b1},
        {8'h02, 1'b0, 8'h00, 1'b1},
        {8'h23, 1'b1, 8'hCD, 1'b1},
        {8'h00, 1'b0, 8'h00, 1'b1},
        {8'h02, 1'b0, 8'h00, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1; io_addr = a; io_wdata = d;
        tick();
        io_wr = 0;
    endtask

    task automatic bus_cycle(input logic [7:0] st);
        cyc_start = 1; status = st;
        tick();
        cyc_start = 0;
    endtask

    task automatic read_stat(output logic [7:0] v);
        io_rd = 1; io_addr = P_STAT;
        #0.5;
        v = io_rdata;
        io_rd = 0;
    endtask

    task automatic expect_out(input string tag, input logic oe, input logic [7:0] d);
        chk(inject_oe == oe, {tag, " oe"}, inject_oe, oe);
        chk(inject_data == d, {tag, " data"}, inject_data, d);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst = 0;
        tick();

        // R1 reset state
        chk(irq == 0, "R1 irq", irq, 0);
        expect_out("R1", 0, 8'h00);
        read_stat(s);
        chk(s == 8'h04, "R1 stat", s, 8'h04);

        // setup for table: R12 control write, R2 raise
        io_write(P_CTRL, 8'h06);
        io_write(P_B0, 8'hCD);
        io_write(P_B1, 8'h34);
        io_write(P_B2, 8'h12);
        io_write(P_REQ, 8'h01);
        chk(irq == 1, "R2 raise", irq, 1);
        read_stat(s);
        chk(s == 8'h02, "R12 wa off readback", s, 8'h02);

        // table: R5, R9, R10
        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            bus_cycle(v[17:10]);
            chk(inject_oe == v[9], $sformatf("R5/R10 step %0d oe", i), inject_oe, v[9]);
            chk(inject_data == v[8:1], $sformatf("R5 step %0d data", i), inject_data, v[8:1]);
            chk(irq == v[0], $sformatf("R9 step %0d irq", i), irq, v[0]);
        end
        read_stat(s);
        chk(s == 8'h02, "R9 no clone flag", s, 8'h02);

        // R12 enable workaround, length 3
        io_write(P_CTRL, 8'h07);
        read_stat(s);
        chk(s == 8'h06, "R12 wa on readback", s, 8'h06);

        // R7 compliant CPU
        bus_cycle(8'h23);
        chk(irq == 1, "R7 irq after ack", irq, 1);
        bus_cycle(8'h02);
        expect_out("R7 low", 1, 8'h34);
        chk(irq == 1, "R7 irq mid", irq, 1);
        bus_cycle(8'h02);
        expect_out("R7 high", 1, 8'h12);
        chk(irq == 0, "R7 irq dropped", irq, 0);

        // R8 clone CPU
        io_write(P_REQ, 8'h01);
        bus_cycle(8'h23);
        bus_cycle(8'h03);
        expect_out("R8 low", 1, 8'h34);
        chk(irq == 0, "R8 irq dropped", irq, 0);
        read_stat(s);
        chk(s == 8'h05, "R8 flag set", s, 8'h05);
        bus_cycle(8'h03);
        expect_out("R8 high", 1, 8'h12);

        // R11 clear
        io_write(P_STAT, 8'h00);
        read_stat(s);
        chk(s == 8'h05, "R11 write0 keeps", s, 8'h05);
        io_write(P_STAT, 8'h01);
        read_stat(s);
        chk(s == 8'h04, "R11 write1 clears", s, 8'h04);

        // R6 length 2
        io_write(P_CTRL, 8'h05);
        io_write(P_REQ, 8'h01);
        bus_cycle(8'h23);
        expect_out("R6 op", 1, 8'hCD);
        bus_cycle(8'h02);
        expect_out("R6 low", 1, 8'h34);
        chk(irq == 0, "R7 len2 drop", irq, 0);
        bus_cycle(8'h02);
        expect_out("R6 no third", 0, 8'h00);

        // R3, R4 length 1 restart
        io_write(P_CTRL, 8'h03);
        io_write(P_B0, 8'hFF);
        io_write(P_REQ, 8'h01);
        bus_cycle(8'h23);
        expect_out("R3 restart", 1, 8'hFF);
        chk(irq == 1, "R4 irq held", irq, 1);
        bus_cycle(8'h02);
        expect_out("R4 no fetch", 0, 8'h00);
        bus_cycle(8'h04);
        bus_cycle(8'h04);
        chk(irq == 1, "R4 irq after stack", irq, 1);
        bus_cycle(8'h23);
        expect_out("R4 reentry", 1, 8'hFF);

        // R2 lower
        io_write(P_REQ, 8'h00);
        chk(irq == 0, "R2 lower", irq, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule